// File: doc/BRIEF.md
# Two-Deep Command Sequencer for a Word Array

This block guards the bus-side protocol used to start operations on a word-organized nonvolatile array. Software starts an operation in three steps. It first writes one aligned word into the array window, which captures the target address and data. It then writes an operation code. Finally it writes 1 to the buffer-empty flag, and that write launches the operation. The block checks each step as it arrives. Any step that is out of order or not allowed cancels the sequence and raises an error flag. While an error flag is set, nothing can be launched.

A launched command waits in a one-entry buffer until the operation engine is free, and then moves into the active slot. This lets software queue a second command while the first is still running. The completion flag rises only when neither slot holds a command. A stop request kills all queued work. The engine behind the block (the program and erase algorithms and the array) sits outside it. The block only hands that engine a start pulse with the opcode, address and data, and receives a done pulse and a blank-check result.

Top module: `cmd_pipe_seq`

## Requirements
- R1: After reset, flag_empty and flag_done are 1, flag_acc, flag_prot, flag_blank and irq are 0, and eng_start is 0.
- R2: A correct sequence clears flag_empty and flag_done one cycle after the launching status write. The engine then receives eng_start with the captured opcode, address and data, and flag_empty returns to 1 once the buffer has moved to the active slot.
- R3: A second command can be launched while the first runs. It waits with flag_empty at 0, starts when the first finishes, and flag_done stays 0 until the second also finishes.
- R4: Accepted codes are 0x05 (blank check), 0x20 (word program), 0x40 (sector erase), 0x41 (full erase) and 0x60 (sector rewrite). Any other code sets flag_acc and starts nothing.
- R5: An array write sets flag_acc and cancels the sequence when any of these holds: div_ok is low, arr_word is low (byte or misaligned access), flag_empty is 0, or a word has already been captured.
- R6: flag_acc is set and the sequence cancelled in each of these cases: after the word, any write other than a code write; after the code, any write other than a status write; a code write with no captured word.
- R7: The status write uses bit 2 for the buffer-empty flag, bit 1 for flag_prot and bit 0 for flag_acc. A status write with bit 2 at 0 cancels a sequence in progress and sets flag_acc. Outside a sequence it changes nothing.
- R8: flag_acc and flag_prot clear only when a 1 is written to their status bit, and writing 0 leaves them set. While either is set, an array write sets flag_acc and no command launches.
- R9: A program, erase or rewrite whose word write saw prot_hit high sets flag_prot at the code write and starts nothing. So does a full erase while prot_any is high. A blank check is not blocked by prot_hit.
- R10: flag_blank sets when a blank-check operation finishes with eng_blank high, and clears at the next launch.
- R11: For sector erase and sector rewrite, eng_addr has bits 1:0 forced to 0. Full erase passes the captured address through unchanged.
- R12: When stop_req rises with a command active or queued, the block pulses eng_abort (when one is active), discards the queued command, and sets flag_done and flag_acc. When stop_req falls, flag_empty is set.
- R13: The interrupt-enable write uses bit 1 for the buffer-empty enable and bit 0 for the completion enable. irq is the OR of flag_empty gated by bit 1 and flag_done gated by bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_wr | input | 1 | Write strobe into the array window |
| arr_addr | input | AW | Byte address of the array write |
| arr_data | input | DW | Data of the array write |
| arr_word | input | 1 | 1 when the array write is an aligned word |
| cmd_wr | input | 1 | Command-code register write strobe |
| cmd_code | input | 8 | Command code written |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 3 | Status write data: [2] buffer-empty, [1] protection error, [0] access error |
| ien_wr | input | 1 | Interrupt-enable register write strobe |
| ien_wdata | input | 2 | [1] buffer-empty enable, [0] completion enable |
| oth_wr | input | 1 | Write to any other register of the block |
| div_ok | input | 1 | Timing divider has been loaded |
| prot_hit | input | 1 | Address of the current array write is protected |
| prot_any | input | 1 | Some protection is active |
| stop_req | input | 1 | Stop-mode request (level) |
| eng_start | output | 1 | Start pulse to the operation engine |
| eng_op | output | 8 | Opcode for the engine |
| eng_addr | output | AW | Address for the engine |
| eng_data | output | DW | Data for the engine |
| eng_abort | output | 1 | Abort pulse for the running operation |
| eng_done | input | 1 | Engine finished the active operation |
| eng_blank | input | 1 | Blank-check result, valid with eng_done |
| flag_empty | output | 1 | Command buffer empty |
| flag_done | output | 1 | All commands complete |
| flag_acc | output | 1 | Access error |
| flag_prot | output | 1 | Protection error |
| flag_blank | output | 1 | Array verified as erased |
| irq | output | 1 | Interrupt request |

## Verification
Several pipeline properties are checked on every cycle. A start handed to the engine refills the buffer-empty flag on the next cycle. The completion flag never coexists with an occupied slot, and it stays low while a command is queued behind an active one. Error flags freeze the buffer-empty flag. An array write with the buffer full always raises the access error, and a stop entry with work active sets both completion and error. The following are shown only by the directed scenarios: each individual sequence violation, the opcode table, address masking for sector operations, the protection exemption for blank checks, the life cycle of the blank flag, stop exit, and the interrupt gating.

// File: rtl/cps_pkg.sv
// Shared definitions for the command sequencer: opcodes, step states and
// opcode classification helpers. Assumes 8-bit command codes.
package cps_pkg;
    localparam int CW = 8;
    localparam logic [CW-1:0] OP_VERIFY = 8'h05;
    localparam logic [CW-1:0] OP_PROG   = 8'h20;
    localparam logic [CW-1:0] OP_SECT   = 8'h40;
    localparam logic [CW-1:0] OP_MASS   = 8'h41;
    localparam logic [CW-1:0] OP_SMOD   = 8'h60;

    typedef enum logic [1:0] {ST_IDLE, ST_WORD, ST_CMD} seq_st_t;

    function automatic logic op_known(input logic [CW-1:0] c);
        return (c == OP_VERIFY) || (c == OP_PROG) || (c == OP_SECT) ||
               (c == OP_MASS) || (c == OP_SMOD);
    endfunction

    function automatic logic op_alters(input logic [CW-1:0] c);
        return c != OP_VERIFY;
    endfunction
endpackage

// File: rtl/seq_front.sv
// Step tracker: follows word write, code write and launch, and reports
// access or protection violations. Assumes at most one bus strobe per cycle.
module seq_front
    import cps_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arr_wr,
    input  logic [AW-1:0] arr_addr,
    input  logic [DW-1:0] arr_data,
    input  logic          arr_word,
    input  logic          cmd_wr,
    input  logic [CW-1:0] cmd_code,
    input  logic          stat_wr,
    input  logic          stat_go,
    input  logic          other_wr,
    input  logic          div_ok,
    input  logic          prot_hit,
    input  logic          prot_any,
    input  logic          buf_empty,
    input  logic          locked,
    input  logic          stop_rise,
    output logic          launch,
    output logic          acc_set,
    output logic          prv_set,
    output logic [CW-1:0] l_op,
    output logic [AW-1:0] l_addr,
    output logic [DW-1:0] l_data
);
    seq_st_t       st, st_nx;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic [CW-1:0] op_q;
    logic          ph_q;
    logic          word_ok, cmd_prot;

    assign word_ok  = div_ok && arr_word && buf_empty && !locked;
    assign cmd_prot = (op_alters(cmd_code) && ph_q) || ((cmd_code == OP_MASS) && prot_any);

    // Next step and violation detection for the current strobe.
    always_comb begin
        st_nx   = st;
        launch  = 1'b0;
        acc_set = 1'b0;
        prv_set = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (arr_wr) begin
                    if (word_ok) st_nx = ST_WORD;
                    else         acc_set = 1'b1;
                end else if (cmd_wr) begin
                    acc_set = 1'b1;
                end
            end
            ST_WORD: begin
                if (arr_wr || stat_wr || other_wr) acc_set = 1'b1;
                else if (cmd_wr) begin
                    if (!op_known(cmd_code)) acc_set = 1'b1;
                    else if (cmd_prot)       prv_set = 1'b1;
                    else                     st_nx = ST_CMD;
                end
            end
            ST_CMD: begin
                if (arr_wr || cmd_wr || other_wr) acc_set = 1'b1;
                else if (stat_wr) begin
                    if (stat_go && !locked) begin
                        launch = 1'b1;
                        st_nx  = ST_IDLE;
                    end else begin
                        acc_set = 1'b1;
                    end
                end
            end
            default: st_nx = ST_IDLE;
        endcase
        if (acc_set || prv_set || stop_rise) begin
            st_nx  = ST_IDLE;
            launch = 1'b0;
        end
    end

    // Step register and capture of word and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            a_q  <= '0;
            d_q  <= '0;
            op_q <= '0;
            ph_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && st_nx == ST_WORD) begin
                a_q  <= arr_addr;
                d_q  <= arr_data;
                ph_q <= prot_hit;
            end
            if (st == ST_WORD && st_nx == ST_CMD) op_q <= cmd_code;
        end
    end

    assign l_op   = op_q;
    assign l_data = d_q;
    assign l_addr = (op_q == OP_SECT || op_q == OP_SMOD) ? {a_q[AW-1:2], 2'b00} : a_q;
endmodule

// File: rtl/seq_pipe.sv
// Two-slot command pipeline: a launched command sits in the buffer until
// the engine is free, then moves to the active slot. Handles stop entry/exit.
module seq_pipe
    import cps_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [CW-1:0] l_op,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_data,
    input  logic          stop_req,
    input  logic          eng_done,
    input  logic          eng_blank,
    output logic          eng_start,
    output logic [CW-1:0] eng_op,
    output logic [AW-1:0] eng_addr,
    output logic [DW-1:0] eng_data,
    output logic          eng_abort,
    output logic          moved,
    output logic          all_done,
    output logic          blank_hit,
    output logic          kill,
    output logic          stop_rise,
    output logic          stop_fall,
    output logic          pend_valid,
    output logic          act_busy
);
    logic          stop_q;
    logic [CW-1:0] act_op;

    assign stop_rise = stop_req && !stop_q;
    assign stop_fall = !stop_req && stop_q;
    assign eng_start = pend_valid && !act_busy && !stop_req;
    assign moved     = eng_start;
    assign kill      = stop_rise && (act_busy || pend_valid);
    assign eng_abort = stop_rise && act_busy;
    assign all_done  = eng_done && act_busy && !pend_valid && !launch && !stop_rise;
    assign blank_hit = eng_done && act_busy && (act_op == OP_VERIFY) && eng_blank && !stop_rise;

    // Stop-request history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= stop_req;
    end

    // Buffer and active-slot occupancy and contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            act_busy   <= 1'b0;
            act_op     <= '0;
            eng_op     <= '0;
            eng_addr   <= '0;
            eng_data   <= '0;
        end else if (stop_rise) begin
            pend_valid <= 1'b0;
            act_busy   <= 1'b0;
        end else begin
            if (eng_start) begin
                act_busy   <= 1'b1;
                act_op     <= eng_op;
                pend_valid <= 1'b0;
            end else if (eng_done && act_busy) begin
                act_busy <= 1'b0;
            end
            if (launch) begin
                pend_valid <= 1'b1;
                eng_op     <= l_op;
                eng_addr   <= l_addr;
                eng_data   <= l_data;
            end
        end
    end
endmodule

// File: rtl/seq_flags.sv
// Status flags, interrupt enables and interrupt request. Set events take
// priority over write-one-to-clear in the same cycle.
module seq_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       acc_set,
    input  logic       prv_set,
    input  logic       stat_wr,
    input  logic [1:0] stat_clr,
    input  logic       ien_wr,
    input  logic [1:0] ien_wdata,
    input  logic       moved,
    input  logic       all_done,
    input  logic       blank_hit,
    input  logic       kill,
    input  logic       stop_fall,
    output logic       flag_empty,
    output logic       flag_done,
    output logic       flag_acc,
    output logic       flag_prot,
    output logic       flag_blank,
    output logic       irq
);
    logic [1:0] ien_q;

    // Flag and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_empty <= 1'b1;
            flag_done  <= 1'b1;
            flag_acc   <= 1'b0;
            flag_prot  <= 1'b0;
            flag_blank <= 1'b0;
            ien_q      <= 2'b00;
        end else begin
            if (launch)                  flag_empty <= 1'b0;
            else if (moved || stop_fall) flag_empty <= 1'b1;
            if (launch)                  flag_done <= 1'b0;
            else if (all_done || kill)   flag_done <= 1'b1;
            if (acc_set || kill)         flag_acc <= 1'b1;
            else if (stat_wr && stat_clr[0]) flag_acc <= 1'b0;
            if (prv_set)                 flag_prot <= 1'b1;
            else if (stat_wr && stat_clr[1]) flag_prot <= 1'b0;
            if (launch)                  flag_blank <= 1'b0;
            else if (blank_hit)          flag_blank <= 1'b1;
            if (ien_wr)                  ien_q <= ien_wdata;
        end
    end

    assign irq = (flag_empty && ien_q[1]) || (flag_done && ien_q[0]);
endmodule

// File: rtl/cmd_pipe_seq.sv
// Top of the command sequencer: step tracker, two-slot pipeline and flags.
// Assumes the bus issues at most one register or array write per cycle.
module cmd_pipe_seq
    import cps_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arr_wr,
    input  logic [AW-1:0] arr_addr,
    input  logic [DW-1:0] arr_data,
    input  logic          arr_word,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_code,
    input  logic          stat_wr,
    input  logic [2:0]    stat_wdata,
    input  logic          ien_wr,
    input  logic [1:0]    ien_wdata,
    input  logic          oth_wr,
    input  logic          div_ok,
    input  logic          prot_hit,
    input  logic          prot_any,
    input  logic          stop_req,
    output logic          eng_start,
    output logic [7:0]    eng_op,
    output logic [AW-1:0] eng_addr,
    output logic [DW-1:0] eng_data,
    output logic          eng_abort,
    input  logic          eng_done,
    input  logic          eng_blank,
    output logic          flag_empty,
    output logic          flag_done,
    output logic          flag_acc,
    output logic          flag_prot,
    output logic          flag_blank,
    output logic          irq
);
    logic          launch, acc_set, prv_set;
    logic [CW-1:0] l_op;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_data;
    logic          moved, all_done, blank_hit, kill, stop_rise, stop_fall;
    logic          pend_valid, act_busy;

    seq_front #(.AW(AW), .DW(DW)) u_front (
        .clk(clk), .rst_n(rst_n),
        .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_data(arr_data), .arr_word(arr_word),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .stat_wr(stat_wr), .stat_go(stat_wdata[2]), .other_wr(ien_wr || oth_wr),
        .div_ok(div_ok), .prot_hit(prot_hit), .prot_any(prot_any),
        .buf_empty(flag_empty), .locked(flag_acc || flag_prot), .stop_rise(stop_rise),
        .launch(launch), .acc_set(acc_set), .prv_set(prv_set),
        .l_op(l_op), .l_addr(l_addr), .l_data(l_data)
    );

    seq_pipe #(.AW(AW), .DW(DW)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .l_op(l_op), .l_addr(l_addr), .l_data(l_data),
        .stop_req(stop_req), .eng_done(eng_done), .eng_blank(eng_blank),
        .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data),
        .eng_abort(eng_abort), .moved(moved), .all_done(all_done), .blank_hit(blank_hit),
        .kill(kill), .stop_rise(stop_rise), .stop_fall(stop_fall),
        .pend_valid(pend_valid), .act_busy(act_busy)
    );

    seq_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .acc_set(acc_set), .prv_set(prv_set),
        .stat_wr(stat_wr), .stat_clr(stat_wdata[1:0]),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .moved(moved), .all_done(all_done), .blank_hit(blank_hit),
        .kill(kill), .stop_fall(stop_fall),
        .flag_empty(flag_empty), .flag_done(flag_done), .flag_acc(flag_acc),
        .flag_prot(flag_prot), .flag_blank(flag_blank), .irq(irq)
    );
endmodule

// File: rtl/cps_checker.sv
// Cycle-level properties of the sequencer, attached to every instance of
// the top module by the bind below.
module cps_checker (
    input logic clk,
    input logic rst_n,
    input logic arr_wr,
    input logic stop_req,
    input logic eng_start,
    input logic flag_empty,
    input logic flag_done,
    input logic flag_acc,
    input logic flag_prot,
    input logic pend_valid,
    input logic act_busy
);
    p_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> flag_empty);

    p_done_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_done |-> (!act_busy && !pend_valid));

    p_hold_queued_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_busy && pend_valid && !stop_req) |=> !flag_done);

    p_full_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_empty && arr_wr) |=> flag_acc);

    p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_acc || flag_prot) && flag_empty) |=> flag_empty);

    p_stop_kill_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stop_req) && act_busy) |=> (flag_acc && flag_done));
endmodule

bind cmd_pipe_seq cps_checker u_chk (
    .clk(clk), .rst_n(rst_n), .arr_wr(arr_wr), .stop_req(stop_req),
    .eng_start(eng_start), .flag_empty(flag_empty), .flag_done(flag_done),
    .flag_acc(flag_acc), .flag_prot(flag_prot),
    .pend_valid(pend_valid), .act_busy(act_busy)
);

// File: tb/sim_cmd_pipe_seq.sv
`timescale 1ns/1ps
// Directed bench for the command sequencer, with a latency-based engine model.
module sim_cmd_pipe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arr_wr = 0, arr_word = 1, cmd_wr = 0, stat_wr = 0, ien_wr = 0, oth_wr = 0;
    logic [11:0] arr_addr = '0;
    logic [15:0] arr_data = '0;
    logic [7:0]  cmd_code = '0;
    logic [2:0]  stat_wdata = '0;
    logic [1:0]  ien_wdata = '0;
    logic        div_ok = 0, prot_hit = 0, prot_any = 0, stop_req = 0;
    logic        eng_done = 0, eng_blank = 0;
    logic        eng_start, eng_abort;
    logic [7:0]  eng_op;
    logic [11:0] eng_addr;
    logic [15:0] eng_data;
    logic        flag_empty, flag_done, flag_acc, flag_prot, flag_blank, irq;

    int n_chk = 0, n_fail = 0;
    int lat = 3, cnt = 0, n_starts = 0, n_aborts = 0;
    logic [7:0]  last_op;
    logic [11:0] last_addr;
    logic [15:0] last_data;

    always #5 clk = ~clk;

    cmd_pipe_seq u0 (
        .clk(clk), .rst_n(rst_n), .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_data(arr_data),
        .arr_word(arr_word), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata), .oth_wr(oth_wr),
        .div_ok(div_ok), .prot_hit(prot_hit), .prot_any(prot_any), .stop_req(stop_req),
        .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data),
        .eng_abort(eng_abort), .eng_done(eng_done), .eng_blank(eng_blank),
        .flag_empty(flag_empty), .flag_done(flag_done), .flag_acc(flag_acc),
        .flag_prot(flag_prot), .flag_blank(flag_blank), .irq(irq)
    );

    // Engine model: acts 1 ns after each falling edge, done after lat cycles.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            eng_done = 1'b0;
            if (eng_abort) begin
                cnt = 0;
                n_aborts++;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) eng_done = 1'b1;
            end
            if (eng_start) begin
                cnt = lat;
                n_starts++;
                last_op = eng_op;
                last_addr = eng_addr;
                last_data = eng_data;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_arr(input logic [11:0] a, input logic [15:0] d, input logic w);
        arr_addr = a; arr_data = d; arr_word = w; arr_wr = 1'b1;
        @(negedge clk);
        arr_wr = 1'b0; arr_word = 1'b1;
    endtask

    task automatic wr_cmd(input logic [7:0] c);
        cmd_code = c; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wr_stat(input logic [2:0] v);
        stat_wdata = v; stat_wr = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic wr_ien(input logic [1:0] v);
        ien_wdata = v; ien_wr = 1'b1;
        @(negedge clk);
        ien_wr = 1'b0;
    endtask

    task automatic wr_oth();
        oth_wr = 1'b1;
        @(negedge clk);
        oth_wr = 1'b0;
    endtask

    task automatic run_seq(input logic [7:0] op, input logic [11:0] a, input logic [15:0] d);
        wr_arr(a, d, 1'b1);
        wr_cmd(op);
        wr_stat(3'b100);
    endtask

    task automatic wait_done();
        for (int k = 0; k < 500 && !flag_done; k++) @(negedge clk);
    endtask

    task automatic clear_errs();
        wr_stat(3'b011);
    endtask

    task automatic t_reset();
        chk("R1", "empty", flag_empty, 1);
        chk("R1", "done", flag_done, 1);
        chk("R1", "acc/prot/blank", {flag_acc, flag_prot, flag_blank}, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "start", eng_start, 0);
    endtask

    task automatic t_program();
        run_seq(8'h20, 12'h124, 16'hBEEF);
        chk("R2", "empty after launch", flag_empty, 0);
        chk("R2", "done after launch", flag_done, 0);
        idle(1);
        chk("R2", "empty refilled", flag_empty, 1);
        chk("R2", "engine op", last_op, 8'h20);
        chk("R2", "engine addr", last_addr, 12'h124);
        chk("R2", "engine data", last_data, 16'hBEEF);
        wait_done();
        chk("R2", "done at end", flag_done, 1);
    endtask

    task automatic t_pipeline();
        int s0;
        lat = 20;
        s0 = n_starts;
        run_seq(8'h20, 12'h010, 16'h1111);
        idle(1);
        run_seq(8'h20, 12'h020, 16'h2222);
        chk("R3", "empty while queued", flag_empty, 0);
        for (int k = 0; k < 100 && n_starts < s0 + 2; k++) @(negedge clk);
        chk("R3", "second started", n_starts - s0, 2);
        chk("R3", "done low after first", flag_done, 0);
        chk("R3", "empty after move", flag_empty, 1);
        wait_done();
        chk("R3", "done after both", flag_done, 1);
        chk("R3", "second addr", last_addr, 12'h020);
        lat = 3;
    endtask

    task automatic t_bad_code();
        int s0 = n_starts;
        wr_arr(12'h040, 16'h0, 1'b1);
        wr_cmd(8'h33);
        chk("R4", "acc on bad code", flag_acc, 1);
        clear_errs();
        chk("R4", "acc cleared", flag_acc, 0);
        idle(3);
        chk("R4", "no start", n_starts - s0, 0);
    endtask

    task automatic t_arr_viol();
        div_ok = 0;
        wr_arr(12'h050, 16'h0, 1'b1);
        chk("R5", "divider not loaded", flag_acc, 1);
        clear_errs();
        div_ok = 1;
        wr_arr(12'h051, 16'h0, 1'b0);
        chk("R5", "byte write", flag_acc, 1);
        clear_errs();
        wr_arr(12'h052, 16'h0, 1'b1);
        wr_arr(12'h054, 16'h0, 1'b1);
        chk("R5", "second word", flag_acc, 1);
        clear_errs();
        lat = 20;
        run_seq(8'h20, 12'h060, 16'h0);
        idle(1);
        run_seq(8'h20, 12'h062, 16'h0);
        wr_arr(12'h064, 16'h0, 1'b1);
        chk("R5", "word while buffer full", flag_acc, 1);
        clear_errs();
        wait_done();
        lat = 3;
    endtask

    task automatic t_order_viol();
        int s0 = n_starts;
        wr_arr(12'h070, 16'h0, 1'b1);
        wr_ien(2'b00);
        chk("R6", "ien write after word", flag_acc, 1);
        clear_errs();
        wr_arr(12'h070, 16'h0, 1'b1);
        wr_oth();
        chk("R6", "other write after word", flag_acc, 1);
        clear_errs();
        wr_arr(12'h070, 16'h0, 1'b1);
        wr_cmd(8'h20);
        wr_cmd(8'h20);
        chk("R6", "second code", flag_acc, 1);
        clear_errs();
        wr_arr(12'h070, 16'h0, 1'b1);
        wr_cmd(8'h20);
        wr_oth();
        chk("R6", "other write after code", flag_acc, 1);
        clear_errs();
        wr_cmd(8'h20);
        chk("R6", "code with no word", flag_acc, 1);
        clear_errs();
        idle(3);
        chk("R6", "no start", n_starts - s0, 0);
    endtask

    task automatic t_zero_empty();
        wr_arr(12'h080, 16'h0, 1'b1);
        wr_stat(3'b000);
        chk("R7", "zero after word", flag_acc, 1);
        clear_errs();
        wr_arr(12'h080, 16'h0, 1'b1);
        wr_cmd(8'h20);
        wr_stat(3'b000);
        chk("R7", "zero after code", flag_acc, 1);
        clear_errs();
        wr_stat(3'b000);
        chk("R7", "zero outside: flags", {flag_empty, flag_done, flag_acc, flag_prot}, 4'b1100);
    endtask

    task automatic t_lock();
        int s0;
        wr_arr(12'h090, 16'h0, 1'b1);
        wr_cmd(8'hFF);
        wr_stat(3'b000);
        chk("R8", "acc holds on zero", flag_acc, 1);
        wr_stat(3'b010);
        chk("R8", "acc holds on other bit", flag_acc, 1);
        s0 = n_starts;
        wr_arr(12'h090, 16'h0, 1'b1);
        wr_cmd(8'h20);
        wr_stat(3'b100);
        idle(3);
        chk("R8", "no launch while locked", n_starts - s0, 0);
        chk("R8", "empty kept", flag_empty, 1);
        clear_errs();
        chk("R8", "acc cleared by one", flag_acc, 0);
    endtask

    task automatic t_protect();
        int s0 = n_starts;
        prot_hit = 1;
        wr_arr(12'hFC0, 16'h0, 1'b1);
        wr_cmd(8'h20);
        chk("R9", "program protected", flag_prot, 1);
        wr_stat(3'b000);
        chk("R8", "prot holds on zero", flag_prot, 1);
        wr_stat(3'b010);
        chk("R9", "prot cleared", flag_prot, 0);
        wr_arr(12'hFC4, 16'h0, 1'b1);
        wr_cmd(8'h40);
        chk("R9", "erase protected", flag_prot, 1);
        clear_errs();
        chk("R9", "no start", n_starts - s0, 0);
        run_seq(8'h05, 12'hFC8, 16'h0);
        chk("R9", "verify not blocked", flag_prot, 0);
        wait_done();
        chk("R9", "verify ran", n_starts - s0, 1);
        prot_hit = 0;
        prot_any = 1;
        wr_arr(12'h100, 16'h0, 1'b1);
        wr_cmd(8'h41);
        chk("R9", "full erase protected", flag_prot, 1);
        clear_errs();
        prot_any = 0;
    endtask

    task automatic t_blank();
        eng_blank = 1;
        run_seq(8'h05, 12'h200, 16'h0);
        wait_done();
        idle(1);
        chk("R10", "blank set", flag_blank, 1);
        eng_blank = 0;
        run_seq(8'h20, 12'h202, 16'h5A5A);
        chk("R10", "blank cleared at launch", flag_blank, 0);
        wait_done();
    endtask

    task automatic t_addr();
        run_seq(8'h40, 12'h126, 16'h0);
        wait_done();
        chk("R11", "sector erase addr", last_addr, 12'h124);
        run_seq(8'h60, 12'h0FA, 16'h77);
        wait_done();
        chk("R11", "rewrite addr", last_addr, 12'h0F8);
        run_seq(8'h41, 12'h3A6, 16'h0);
        wait_done();
        chk("R11", "full erase addr", last_addr, 12'h3A6);
        chk("R4", "full erase op", last_op, 8'h41);
    endtask

    task automatic t_stop();
        int s0, a0;
        lat = 40;
        run_seq(8'h20, 12'h300, 16'h0);
        idle(1);
        run_seq(8'h20, 12'h302, 16'h0);
        s0 = n_starts;
        a0 = n_aborts;
        stop_req = 1;
        @(negedge clk);
        chk("R12", "acc and done", {flag_acc, flag_done}, 2'b11);
        chk("R12", "empty still low", flag_empty, 0);
        idle(3);
        chk("R12", "engine aborted", n_aborts - a0, 1);
        chk("R12", "queued dropped", n_starts - s0, 0);
        stop_req = 0;
        @(negedge clk);
        chk("R12", "empty on exit", flag_empty, 1);
        clear_errs();
        idle(3);
        chk("R12", "still no start", n_starts - s0, 0);
        lat = 3;
    endtask

    task automatic t_irq();
        wr_ien(2'b10);
        chk("R13", "empty enable", irq, 1);
        wr_ien(2'b00);
        chk("R13", "disabled", irq, 0);
        wr_ien(2'b01);
        chk("R13", "done enable", irq, 1);
        lat = 10;
        run_seq(8'h20, 12'h400, 16'h0);
        chk("R13", "after launch", irq, 0);
        idle(1);
        chk("R13", "running, done enable", irq, 0);
        wr_ien(2'b10);
        chk("R13", "running, empty enable", irq, 1);
        wr_ien(2'b01);
        wait_done();
        chk("R13", "complete", irq, 1);
        lat = 3;
    endtask

    // Main sequence of scenarios.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        div_ok = 1;
        t_program();
        t_pipeline();
        t_bad_code();
        t_arr_viol();
        t_order_viol();
        t_zero_empty();
        t_lock();
        t_protect();
        t_blank();
        t_addr();
        t_stop();
        t_irq();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule